// File: doc/BRIEF.md
# Oldest-First Crossbar Match Scheduler

This block decides which connections an N-by-N non-blocking crossbar makes. It sits behind a set of per-destination input queues, one queue for every input/output pair. For each queue it sees whether the queue holds a packet, how long that head packet has waited (its age), and how large it is. From these it builds a conflict-free set of input-to-output connections. The oldest waiting head packet always wins, and the match is grown greedily until no compatible request is left.

Two connection disciplines are selectable at run time. In slot mode every connection is made and released together at fixed slot boundaries. The slot lasts at least as long as the largest packet takes to cross. In packet mode each connection is made as soon as its input and its output are both idle. It is then held for exactly as many cycles as the packet has size units, at one unit per cycle. Every new connection pulses a dequeue strobe toward the queue that was served.

Top module: `xbar_oldest_sched`

## Requirements
- R1: While reset is held and in the first sample after it, out_sel, in_busy and voq_deq are all zero.
- R2: No output is ever connected to more than one input, and no input is ever connected to more than one output.
- R3: A larger age value means an older packet. When requests compete for the same input or output, the one with the larger age is granted.
- R4: Among requests of equal age, the lower input index wins, and then the lower output index.
- R5: After the oldest request is granted, matching repeats over the still-free inputs and outputs, so every compatible request left over is also granted in the same decision.
- R6: In slot mode (mode_async = 0), connections change only at slot boundaries. Boundaries occur at the first clock edge after reset and then every SLOT_LEN edges. At each boundary all old connections are dropped and a fresh match is made; in between, the connections hold for the whole slot, whatever the packet sizes are.
- R7: In slot mode, a request that appears in the middle of a slot is not granted before the next boundary, even when its input and output are idle.
- R8: In packet mode (mode_async = 1), a granted connection is visible for exactly P cycles, where P is the head packet size and size 0 counts as 1. After that it is gone for at least one cycle before its ports take a new connection.
- R9: voq_deq[q] is high for exactly one cycle, in the first cycle that connection q is visible, once per granted packet.
- R10: Queue q = i*N_PORTS + o serves input i to output o. Its age is voq_age[q*AGE_W +: AGE_W] and its size is voq_size[q*SIZE_W +: SIZE_W]. Bit o*N_PORTS + i of out_sel is set when output o takes input i, and in_busy[i] is set while input i is connected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_async | input | 1 | 0 = slot mode, 1 = packet mode; change only while no connection is held |
| voq_valid | input | N_PORTS*N_PORTS | Queue q holds a head packet |
| voq_age | input | N_PORTS*N_PORTS*AGE_W | Head packet waiting time per queue |
| voq_size | input | N_PORTS*N_PORTS*SIZE_W | Head packet size per queue |
| voq_deq | output | N_PORTS*N_PORTS | One-cycle dequeue strobe per queue |
| out_sel | output | N_PORTS*N_PORTS | Per-output one-hot source input select |
| in_busy | output | N_PORTS | Input currently connected |

## Verification
The embedded properties watch the structural rules on every cycle: one input per output, one output per input, and a dequeue strobe that is a single cycle and only appears alongside its connection. They also check that slot-mode connections never move between boundaries, and that a packet-mode connection is kept until its counter runs out and is then dropped on the next edge. Whether the right connection was chosen cannot be seen by those properties. Age ordering, the tie order, the greedy fill of leftover ports, the exact boundary cycles and the exact hold length in cycles are shown only by the bench's scenarios, which predict every output pattern at a named cycle.

// File: rtl/xbar_sched_pkg.sv
package xbar_sched_pkg;

    typedef enum logic {
        CONN_SLOT   = 1'b0,
        CONN_PACKET = 1'b1
    } conn_mode_e;

    function automatic int unsigned src_of(input int unsigned q, input int unsigned n);
        return q / n;
    endfunction

    function automatic int unsigned dst_of(input int unsigned q, input int unsigned n);
        return q % n;
    endfunction

endpackage

// File: rtl/oldest_matcher.sv
module oldest_matcher #(
    parameter int N_PORTS = 4,
    parameter int AGE_W   = 8,
    localparam int NQ     = N_PORTS * N_PORTS
) (
    input  logic [NQ-1:0]       req,
    input  logic [NQ*AGE_W-1:0] age,
    input  logic [N_PORTS-1:0]  in_free,
    input  logic [N_PORTS-1:0]  out_free,
    output logic [NQ-1:0]       grant
);
    import xbar_sched_pkg::*;

    logic [N_PORTS-1:0] in_av;
    logic [N_PORTS-1:0] out_av;
    logic               found;
    int unsigned        best;
    logic [AGE_W-1:0]   best_age;

    // Greedy passes: each pass grants the oldest request still compatible
    // with the free ports; strict comparison keeps the lowest flat index on ties.
    always_comb begin
        in_av    = in_free;
        out_av   = out_free;
        grant    = '0;
        found    = 1'b0;
        best     = 0;
        best_age = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            found    = 1'b0;
            best     = 0;
            best_age = '0;
            for (int q = 0; q < NQ; q++) begin
                if (req[q] && in_av[src_of(q, N_PORTS)] && out_av[dst_of(q, N_PORTS)]) begin
                    if (!found || (age[q*AGE_W +: AGE_W] > best_age)) begin
                        found    = 1'b1;
                        best     = q;
                        best_age = age[q*AGE_W +: AGE_W];
                    end
                end
            end
            if (found) begin
                grant[best]                     = 1'b1;
                in_av[src_of(best, N_PORTS)]    = 1'b0;
                out_av[dst_of(best, N_PORTS)]   = 1'b0;
            end
        end
    end

endmodule

// File: rtl/slot_timer.sv
module slot_timer #(
    parameter int SLOT_LEN = 8,
    localparam int CNT_W   = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic slot_edge
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_LEN - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // Starts on the last count so the first edge after reset is a boundary.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LAST;
        else        cnt_q <= cnt_d;
    end

    assign slot_edge = (cnt_q == LAST);

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int N_PORTS = 4,
    parameter int SIZE_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_PORTS-1:0]        load,
    input  logic [N_PORTS*SIZE_W-1:0] load_len,
    output logic [N_PORTS-1:0]        last
);
    logic [N_PORTS*SIZE_W-1:0] rem_d, rem_q;

    for (genvar i = 0; i < N_PORTS; i++) begin : g_lane
        logic [SIZE_W-1:0] len_i;
        assign len_i = load_len[i*SIZE_W +: SIZE_W];

        always_comb begin
            rem_d[i*SIZE_W +: SIZE_W] = rem_q[i*SIZE_W +: SIZE_W];
            if (load[i]) begin
                rem_d[i*SIZE_W +: SIZE_W] = (len_i == '0) ? '0 : len_i - 1'b1;
            end else if (rem_q[i*SIZE_W +: SIZE_W] != '0) begin
                rem_d[i*SIZE_W +: SIZE_W] = rem_q[i*SIZE_W +: SIZE_W] - 1'b1;
            end
        end

        assign last[i] = (rem_q[i*SIZE_W +: SIZE_W] == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

endmodule

// File: rtl/xbar_oldest_sched.sv
module xbar_oldest_sched #(
    parameter int N_PORTS  = 4,
    parameter int AGE_W    = 8,
    parameter int MAX_PKT  = 8,
    parameter int SLOT_LEN = 8,
    localparam int NQ      = N_PORTS * N_PORTS,
    localparam int SIZE_W  = $clog2(MAX_PKT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_async,
    input  logic [NQ-1:0]        voq_valid,
    input  logic [NQ*AGE_W-1:0]  voq_age,
    input  logic [NQ*SIZE_W-1:0] voq_size,
    output logic [NQ-1:0]        voq_deq,
    output logic [NQ-1:0]        out_sel,
    output logic [N_PORTS-1:0]   in_busy
);
    import xbar_sched_pkg::*;

    if (SLOT_LEN < MAX_PKT) begin : g_bad_slot
        $error("SLOT_LEN must cover the largest packet");
    end

    typedef struct packed {
        logic [NQ-1:0] conn;
        logic [NQ-1:0] deq;
    } sched_state_t;

    sched_state_t st_d, st_q;

    conn_mode_e                mode;
    logic                      slot_edge;
    logic [N_PORTS-1:0]        out_busy;
    logic [N_PORTS-1:0]        in_free;
    logic [N_PORTS-1:0]        out_free;
    logic [NQ-1:0]             grant;
    logic [N_PORTS-1:0]        hold_load;
    logic [N_PORTS*SIZE_W-1:0] hold_len;
    logic [N_PORTS-1:0]        hold_last;

    assign mode = conn_mode_e'(mode_async);

    // Port occupancy derived from the registered connection matrix.
    for (genvar i = 0; i < N_PORTS; i++) begin : g_in_busy
        assign in_busy[i] = |st_q.conn[i*N_PORTS +: N_PORTS];
    end

    for (genvar o = 0; o < N_PORTS; o++) begin : g_out
        logic [N_PORTS-1:0] col;
        for (genvar i = 0; i < N_PORTS; i++) begin : g_bit
            assign col[i]                 = st_q.conn[i*N_PORTS + o];
            assign out_sel[o*N_PORTS + i] = st_q.conn[i*N_PORTS + o];
        end
        assign out_busy[o] = |col;
    end

    // Slot mode matches over an empty fabric; packet mode only over idle ports.
    assign in_free  = (mode == CONN_SLOT) ? '1 : ~in_busy;
    assign out_free = (mode == CONN_SLOT) ? '1 : ~out_busy;

    slot_timer #(
        .SLOT_LEN (SLOT_LEN)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_edge (slot_edge)
    );

    oldest_matcher #(
        .N_PORTS (N_PORTS),
        .AGE_W   (AGE_W)
    ) u_match (
        .req      (voq_valid),
        .age      (voq_age),
        .in_free  (in_free),
        .out_free (out_free),
        .grant    (grant)
    );

    hold_timer #(
        .N_PORTS (N_PORTS),
        .SIZE_W  (SIZE_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_load),
        .load_len (hold_len),
        .last     (hold_last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.deq  = '0;
        hold_load = '0;
        hold_len  = '0;
        if (mode == CONN_SLOT) begin
            if (slot_edge) begin
                st_d.conn = grant;
                st_d.deq  = grant;
            end
        end else begin
            for (int i = 0; i < N_PORTS; i++) begin
                if (in_busy[i] && hold_last[i]) begin
                    st_d.conn[i*N_PORTS +: N_PORTS] = '0;
                end
            end
            st_d.conn = st_d.conn | grant;
            st_d.deq  = grant;
            for (int q = 0; q < NQ; q++) begin
                if (grant[q]) begin
                    hold_load[src_of(q, N_PORTS)]                     = 1'b1;
                    hold_len[src_of(q, N_PORTS)*SIZE_W +: SIZE_W]    = voq_size[q*SIZE_W +: SIZE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign voq_deq = st_q.deq;

    // ---------------- assertions ----------------
    for (genvar o = 0; o < N_PORTS; o++) begin : g_ast_out
        AST_OUT_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(out_sel[o*N_PORTS +: N_PORTS])); // R2
    end

    for (genvar i = 0; i < N_PORTS; i++) begin : g_ast_in
        AST_IN_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(st_q.conn[i*N_PORTS +: N_PORTS])); // R2
        AST_PKT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_async && in_busy[i] && !hold_last[i]) |=> in_busy[i]); // R8
        AST_PKT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_async && in_busy[i] && hold_last[i]) |=> !in_busy[i]); // R8
        AST_GRANT_IDLE_IN: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_async && in_busy[i]) |-> (grant[i*N_PORTS +: N_PORTS] == '0)); // R2
    end

    for (genvar q = 0; q < NQ; q++) begin : g_ast_q
        AST_DEQ_WITH_CONN: assert property (@(posedge clk) disable iff (!rst_n)
            voq_deq[q] |-> out_sel[(q % N_PORTS)*N_PORTS + (q / N_PORTS)]); // R9
        AST_DEQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_async && voq_deq[q]) |=> (!voq_deq[q] || !mode_async)); // R9
    end

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_async && !slot_edge) |=> $stable(out_sel)); // R6

    AST_SLOT_NO_DEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_async && !slot_edge) |=> (voq_deq == '0)); // R7

endmodule

// File: tb/sim_xbar_oldest_sched.sv
module sim_xbar_oldest_sched;
    localparam int N      = 4;
    localparam int AGE_W  = 8;
    localparam int MAXP   = 8;
    localparam int SLOT   = 8;
    localparam int NQ     = N * N;
    localparam int SIZE_W = $clog2(MAXP + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 mode_async = 1'b1;
    logic [NQ-1:0]        voq_valid = '0;
    logic [NQ*AGE_W-1:0]  voq_age = '0;
    logic [NQ*SIZE_W-1:0] voq_size = '0;
    logic [NQ-1:0]        voq_deq;
    logic [NQ-1:0]        out_sel;
    logic [N-1:0]         in_busy;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int            at;
        logic [NQ-1:0] sel;
        logic [N-1:0]  busy;
        logic [NQ-1:0] deq;
        string         tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    xbar_oldest_sched #(
        .N_PORTS (N),
        .AGE_W   (AGE_W),
        .MAX_PKT (MAXP),
        .SLOT_LEN(SLOT)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_async (mode_async),
        .voq_valid  (voq_valid),
        .voq_age    (voq_age),
        .voq_size   (voq_size),
        .voq_deq    (voq_deq),
        .out_sel    (out_sel),
        .in_busy    (in_busy)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    function automatic logic [NQ-1:0] sb(input int i, input int o);
        return NQ'(1) << (o*N + i);
    endfunction

    function automatic logic [NQ-1:0] qb(input int q);
        return NQ'(1) << q;
    endfunction

    task automatic compare(input exp_t e);
        compared++;
        if (out_sel !== e.sel || in_busy !== e.busy || voq_deq !== e.deq) begin
            mismatched++;
            $display("FAIL %s cyc %0d: actual sel=%h busy=%b deq=%h expected sel=%h busy=%b deq=%h",
                     e.tag, cyc, out_sel, in_busy, voq_deq, e.sel, e.busy, e.deq);
        end
    endtask

    task automatic expect_at(input int at, input logic [NQ-1:0] sel, input logic [N-1:0] busy,
                             input logic [NQ-1:0] deq, input string tag);
        exp_t e;
        e.at = at; e.sel = sel; e.busy = busy; e.deq = deq; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: pops every expectation due at this sample point.
    always @(negedge clk) begin
        if (rst_n) begin
            while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.at == cyc) compare(e);
                else begin
                    compared++;
                    mismatched++;
                    $display("FAIL %s: actual sample missed at cyc %0d expected cyc %0d", e.tag, cyc, e.at);
                end
            end
        end
    end

    task automatic set_req(input int q, input int a, input int s);
        voq_valid[q] = 1'b1;
        voq_age[q*AGE_W +: AGE_W] = AGE_W'(a);
        voq_size[q*SIZE_W +: SIZE_W] = SIZE_W'(s);
    endtask

    task automatic drop_req(input int q);
        voq_valid[q] = 1'b0;
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        r.at = 0; r.sel = '0; r.busy = '0; r.deq = '0; r.tag = "R1 reset";
        compare(r);
        rst_n = 1'b1;

        // Packet mode: older packet wins an output, exact hold lengths (R3, R8, R9)
        expect_at(3, sb(2,1), 4'b0100, qb(9), "R3 older wins output");
        expect_at(4, sb(2,1), 4'b0100, '0,    "R9 single dequeue pulse");
        expect_at(5, '0,      4'b0000, '0,    "R8 release after size 2");
        expect_at(6, sb(0,1), 4'b0001, qb(1), "R8 freed output regranted");
        expect_at(8, sb(0,1), 4'b0001, '0,    "R8 held for size 3");
        expect_at(9, '0,      4'b0000, '0,    "R8 release after size 3");
        wait_cyc(2);
        set_req(1, 5, 3);
        set_req(9, 9, 2);
        wait_cyc(3); drop_req(9);
        wait_cyc(6); drop_req(1);

        // Packet mode: equal ages, greedy fill, size 0 as one cycle (R4, R5, R10)
        expect_at(13, sb(0,3) | sb(1,0) | sb(2,2), 4'b0111, qb(3) | qb(4) | qb(10), "R4 R5 tie order greedy fill");
        expect_at(14, '0, 4'b0000, '0, "R8 size 1 held one cycle");
        expect_at(15, sb(1,2) | sb(3,0), 4'b1010, qb(6) | qb(12), "R5 leftovers matched next");
        expect_at(16, '0, 4'b0000, '0, "R8 size 0 counts as 1");
        wait_cyc(12);
        set_req(3, 7, 1); set_req(4, 7, 1); set_req(6, 7, 0);
        set_req(10, 7, 1); set_req(12, 7, 1);
        wait_cyc(13); drop_req(3); drop_req(4); drop_req(10);
        wait_cyc(15); drop_req(6); drop_req(12);

        // Packet mode: input-side competition decided by age (R3, R2)
        expect_at(21, sb(0,2), 4'b0001, qb(2), "R3 older wins input");
        expect_at(22, '0, 4'b0000, '0, "R2 blocked requests wait");
        expect_at(23, sb(0,0) | sb(1,2), 4'b0011, qb(0) | qb(6), "R2 both match after release");
        expect_at(24, '0, 4'b0000, '0, "R8 both released");
        wait_cyc(20);
        set_req(0, 3, 1); set_req(2, 200, 1); set_req(6, 100, 1);
        wait_cyc(21); drop_req(2);
        wait_cyc(23); drop_req(0); drop_req(6);

        // Slot mode: boundaries at edges 33, 41, 49 (R6, R7, R4)
        wait_cyc(26);
        mode_async = 1'b0;
        expect_at(33, sb(0,1) | sb(2,3), 4'b0101, qb(1) | qb(11), "R6 R4 slot boundary match");
        expect_at(37, sb(0,1) | sb(2,3), 4'b0101, '0, "R7 mid-slot request waits");
        expect_at(40, sb(0,1) | sb(2,3), 4'b0101, '0, "R6 held whole slot");
        expect_at(41, sb(3,1) | sb(1,0), 4'b1010, qb(13) | qb(4), "R6 next slot rematch");
        expect_at(48, sb(3,1) | sb(1,0), 4'b1010, '0, "R6 held to slot end");
        expect_at(49, '0, 4'b0000, '0, "R6 torn down at boundary");
        wait_cyc(32);
        set_req(1, 4, 8); set_req(13, 4, 2); set_req(11, 1, 5);
        wait_cyc(33); drop_req(1); drop_req(11);
        wait_cyc(36); set_req(4, 50, 1);
        wait_cyc(41); drop_req(13); drop_req(4);

        wait_cyc(52);
        if (exp_q.size() != 0) begin
            compared++;
            mismatched++;
            $display("FAIL R1 leftover: actual %0d pending expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL R1 watchdog: actual cyc %0d expected completion by 52", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule